// File: doc/BRIEF.md
# Compact-ISA ALU Instruction Expander

This block turns one 16-bit instruction from a compact instruction set into the equivalent 32-bit data-processing word of the wider base instruction set. It handles the groups whose top five bits (`[15:11]`) are 0 to 8:

- shift by immediate;
- three-operand add and subtract with a register or a 3-bit immediate;
- the four 8-bit immediate operations;
- the sixteen register-to-register ALU operations;
- add, compare, move and branch-exchange on the extended register file.

Each supported format has its bit fields moved into the fixed fields of the 32-bit encoding. The sixteen register ALU operations are further sorted into four operand-placement layouts.

Any instruction outside these groups is flagged as undefined, as is any unassigned code inside them. A version-5 enable decides whether the two link-exchange codes are accepted. The expander is meant to sit in a decode pipeline in front of a decoder that only understands the wide encoding. It captures its result in one register stage.

Top module: `cxp_expander`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs become `o_word` = 0, `o_valid` = 0 and `o_undef` = 0.
- R2: The result for the inputs present at a rising edge appears on the outputs right after that edge. It stays unchanged when the inputs move between edges.
- R3: For instruction groups 0 to 2, the output is 0xE1B00000 with the following fields placed: instruction bits 12:11 at 6:5, bits 10:6 at 11:7, bits 5:3 at 3:0 and bits 2:0 at 15:12.
- R4: For group 3, instruction bits 10:9 select the base: 0 gives 0xE0900000, 1 gives 0xE0500000, 2 gives 0xE2900000 and 3 gives 0xE2500000. Bits 8:6 go to output 3:0, bits 5:3 to 19:16 and bits 2:0 to 15:12.
- R5: For groups 4 to 7, instruction bits 12:11 select the base: 0 gives 0xE3B00000, 1 gives 0xE3500000, 2 gives 0xE2900000 and 3 gives 0xE2500000. Bits 7:0 go to output 7:0. Bits 10:8 go to both 19:16 and 15:12.
- R6: In group 8 with bit 10 clear, let d = bits 2:0 and s = bits 5:3. Op codes 0, 1, 5, 6, 8, 10, 11, 12, 14 and 15 (bits 9:6) use these bases in that order: 0xE0100000, 0xE0300000, 0xE0B00000, 0xE0D00000, 0xE1100000, 0xE1500000, 0xE1700000, 0xE1900000, 0xE1D00000 and 0xE1F00000. d is placed at 19:16 and 15:12, and s at 3:0.
- R7: Op codes 2, 3, 4 and 7 in the same group use bases 0xE1B00010, 0xE1B00030, 0xE1B00050 and 0xE1B00070. d is placed at 15:12 and 3:0, and s at 11:8.
- R8: Op code 9 in the same group gives 0xE2700000 with d at 15:12 and s at 19:16.
- R9: Op code 13 in the same group gives 0xE0100090 with d at 19:16 and 11:8, and s at 3:0.
- R10: In group 8 with bit 10 set, the destination number is {bit 7, bits 2:0} and the source number is {bit 6, bits 5:3}. Codes 1–3, 5–7 and 9–11 (bits 9:6) use base 0xE0800000, 0xE1500000 and 0xE1A00000 respectively. The destination goes at 19:16 and 15:12, and the source at 3:0.
- R11: Codes 12 and 13 in that group give 0xE12FFF10 with instruction bits 6:3 at output 3:0, whatever the version-5 enable.
- R12: Codes 14 and 15 give 0xE12FFF30 with bits 6:3 at 3:0 only when `i_v5_en` is 1. With `i_v5_en` at 0 they are undefined. The enable has no effect on any other instruction.
- R13: For hi-register codes 0, 4 and 8, and for groups 9 to 31, the result is `o_undef` = 1, `o_valid` = 0 and `o_word` = 0xDEADC0DE. For every defined instruction, `o_valid` = 1 and `o_undef` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_instr | input | 16 | Compact instruction to expand |
| i_v5_en | input | 1 | Enables the link-exchange codes |
| o_word | output | 32 | Expanded base-ISA word, or the undefined filler |
| o_valid | output | 1 | Expanded word is a defined translation |
| o_undef | output | 1 | Instruction has no translation |

## Verification
The assertions assume that both inputs carry known 0/1 values at every rising edge once reset is released. They relate each output to the inputs captured one edge earlier, so they rely on nothing being held over a longer window. The stimulus drives every input only at falling edges and never leaves either input unknown. It walks all 65536 instruction codes under both enable values, then adds a seeded random run and a directed hold-between-edges case.

// File: rtl/cxp_pkg.sv
package cxp_pkg;
  localparam int HW_W   = 16;
  localparam int WORD_W = 32;
  localparam int GRP_W  = 5;

  typedef logic [HW_W-1:0]   hw_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {LAY_NORM, LAY_SHIFT, LAY_NEG, LAY_MUL} alu_layout_e;

  typedef struct packed {
    word_t       base;
    alu_layout_e lay;
  } alu_entry_t;

  // base word and operand layout of each register-to-register ALU op
  function automatic alu_entry_t alu_entry(input logic [3:0] op);
    alu_entry_t e;
    case (op)
      4'd0:    e = '{32'hE0100000, LAY_NORM};
      4'd1:    e = '{32'hE0300000, LAY_NORM};
      4'd2:    e = '{32'hE1B00010, LAY_SHIFT};
      4'd3:    e = '{32'hE1B00030, LAY_SHIFT};
      4'd4:    e = '{32'hE1B00050, LAY_SHIFT};
      4'd5:    e = '{32'hE0B00000, LAY_NORM};
      4'd6:    e = '{32'hE0D00000, LAY_NORM};
      4'd7:    e = '{32'hE1B00070, LAY_SHIFT};
      4'd8:    e = '{32'hE1100000, LAY_NORM};
      4'd9:    e = '{32'hE2700000, LAY_NEG};
      4'd10:   e = '{32'hE1500000, LAY_NORM};
      4'd11:   e = '{32'hE1700000, LAY_NORM};
      4'd12:   e = '{32'hE1900000, LAY_NORM};
      4'd13:   e = '{32'hE0100090, LAY_MUL};
      4'd14:   e = '{32'hE1D00000, LAY_NORM};
      default: e = '{32'hE1F00000, LAY_NORM};
    endcase
    return e;
  endfunction
endpackage

// File: rtl/cxp_lowgrp.sv
// Groups 0..7: shift-immediate, 3-bit add/sub, 8-bit immediate ops
module cxp_lowgrp
  import cxp_pkg::*;
(
  input  hw_t   instr,
  output word_t word,
  output logic  hit
);
  logic [GRP_W-1:0] grp;
  assign grp = instr[15:11];

  always_comb begin
    word = '0;
    hit  = 1'b1;
    if (grp < 5'd3) begin
      word         = 32'hE1B00000;
      word[6:5]    = instr[12:11];
      word[11:7]   = instr[10:6];
      word[3:0]    = {1'b0, instr[5:3]};
      word[15:12]  = {1'b0, instr[2:0]};
    end else if (grp == 5'd3) begin
      case (instr[10:9])
        2'd0:    word = 32'hE0900000;
        2'd1:    word = 32'hE0500000;
        2'd2:    word = 32'hE2900000;
        default: word = 32'hE2500000;
      endcase
      word[3:0]    = {1'b0, instr[8:6]};
      word[19:16]  = {1'b0, instr[5:3]};
      word[15:12]  = {1'b0, instr[2:0]};
    end else if (grp <= 5'd7) begin
      case (instr[12:11])
        2'd0:    word = 32'hE3B00000;
        2'd1:    word = 32'hE3500000;
        2'd2:    word = 32'hE2900000;
        default: word = 32'hE2500000;
      endcase
      word[7:0]    = instr[7:0];
      word[19:16]  = {1'b0, instr[10:8]};
      word[15:12]  = {1'b0, instr[10:8]};
    end else begin
      hit = 1'b0;
    end
  end
endmodule

// File: rtl/cxp_regalu.sv
// Group 8, bit 10 clear: sixteen register ALU ops in four layouts
module cxp_regalu
  import cxp_pkg::*;
(
  input  hw_t   instr,
  output word_t word,
  output logic  hit
);
  alu_entry_t ent;
  logic [3:0] rd, rs;

  assign hit = (instr[15:11] == 5'd8) && !instr[10];
  assign ent = alu_entry(instr[9:6]);
  assign rd  = {1'b0, instr[2:0]};
  assign rs  = {1'b0, instr[5:3]};

  always_comb begin
    word = ent.base;
    case (ent.lay)
      LAY_NORM: begin
        word[19:16] = rd;
        word[15:12] = rd;
        word[3:0]   = rs;
      end
      LAY_SHIFT: begin
        word[15:12] = rd;
        word[3:0]   = rd;
        word[11:8]  = rs;
      end
      LAY_NEG: begin
        word[15:12] = rd;
        word[19:16] = rs;
      end
      default: begin
        word[19:16] = rd;
        word[11:8]  = rd;
        word[3:0]   = rs;
      end
    endcase
  end
endmodule

// File: rtl/cxp_hireg.sv
// Group 8, bit 10 set: extended-register add/compare/move and exchange
module cxp_hireg
  import cxp_pkg::*;
(
  input  hw_t   instr,
  input  logic  v5_en,
  output word_t word,
  output logic  hit
);
  logic [3:0] rd, rs, code;
  logic       grp_ok;

  assign grp_ok = (instr[15:11] == 5'd8) && instr[10];
  assign rd     = {instr[7], instr[2:0]};
  assign rs     = {instr[6], instr[5:3]};
  assign code   = instr[9:6];

  always_comb begin
    word = '0;
    hit  = grp_ok;
    case (code)
      4'd1, 4'd2, 4'd3:   word = 32'hE0800000 | {12'h0, rd, rd, 8'h0, rs};
      4'd5, 4'd6, 4'd7:   word = 32'hE1500000 | {12'h0, rd, rd, 8'h0, rs};
      4'd9, 4'd10, 4'd11: word = 32'hE1A00000 | {12'h0, rd, rd, 8'h0, rs};
      4'd12, 4'd13:       word = {28'hE12FFF1, instr[6:3]};
      4'd14, 4'd15: begin
        word = {28'hE12FFF3, instr[6:3]};
        hit  = grp_ok && v5_en;
      end
      default:            hit  = 1'b0;
    endcase
  end
endmodule

// File: rtl/cxp_expander.sv
module cxp_expander
  import cxp_pkg::*;
#(
  parameter logic [31:0] UNDEF_FILL = 32'hDEADC0DE
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] i_instr,
  input  logic        i_v5_en,
  output logic [31:0] o_word,
  output logic        o_valid,
  output logic        o_undef
);
  word_t w_low, w_alu, w_hi, w_sel;
  logic  h_low, h_alu, h_hi, any_hit;

  cxp_lowgrp u_low (.instr(i_instr), .word(w_low), .hit(h_low));
  cxp_regalu u_alu (.instr(i_instr), .word(w_alu), .hit(h_alu));
  cxp_hireg  u_hi  (.instr(i_instr), .v5_en(i_v5_en), .word(w_hi), .hit(h_hi));

  assign any_hit = h_low | h_alu | h_hi;

  always_comb begin
    if (h_low)      w_sel = w_low;
    else if (h_alu) w_sel = w_alu;
    else if (h_hi)  w_sel = w_hi;
    else            w_sel = UNDEF_FILL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_word  <= '0;
      o_valid <= 1'b0;
      o_undef <= 1'b0;
    end else begin
      o_word  <= w_sel;
      o_valid <= any_hit;
      o_undef <= !any_hit;
    end
  end

  // decoders never claim the same instruction twice
  AST_ONE_DECODER: assert property (@(posedge clk) disable iff (rst)
    $onehot0({h_low, h_alu, h_hi}));                                      // R13

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(o_valid && o_undef));                                               // R13

  AST_UNDEF_FILL: assert property (@(posedge clk) disable iff (rst)
    o_undef |-> (o_word == UNDEF_FILL));                                  // R13

  AST_OUT_OF_SCOPE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(i_instr[15:11]) > 5'd8)) |-> o_undef);         // R13

  AST_IMM8_COPY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(i_instr[15:13]) == 3'b001))
      |-> (o_word[7:0] == $past(i_instr[7:0]) && o_valid));               // R5

  AST_BX_FORM: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(i_instr[15:10]) == 6'b010001)
       && ($past(i_instr[9:7]) == 3'b110))
      |-> (o_word == {28'hE12FFF1, $past(i_instr[6:3])}));                // R11

  AST_V5_GATE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(i_instr[15:10]) == 6'b010001)
       && ($past(i_instr[9:7]) == 3'b111) && !$past(i_v5_en))
      |-> o_undef);                                                       // R12
endmodule

// File: tb/tb_cxp_expander.sv
module tb_cxp_expander;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] i_instr;
  logic        i_v5_en;
  logic [31:0] o_word;
  logic        o_valid;
  logic        o_undef;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  cxp_expander dut (
    .clk(clk), .rst(rst), .i_instr(i_instr), .i_v5_en(i_v5_en),
    .o_word(o_word), .o_valid(o_valid), .o_undef(o_undef)
  );

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: run did not complete");
      report();
    end
  end

  // independent reference: 33-bit result {undef, word}
  function automatic logic [32:0] ref_model(input logic [15:0] i, input logic v5);
    logic [4:0]  g;
    logic [3:0]  op, rdh, rsh;
    logic [11:0] t12;
    g   = i[15:11];
    op  = i[9:6];
    rdh = {i[7], i[2:0]};
    rsh = {i[6], i[5:3]};
    if (g <= 5'd2)
      return {1'b0, 12'hE1B, 4'h0, 1'b0, i[2:0], i[10:6], i[12:11], 1'b0, 1'b0, i[5:3]};
    if (g == 5'd3) begin
      t12 = {(i[10] ? 8'hE2 : 8'hE0), (i[9] ? 4'h5 : 4'h9)};
      return {1'b0, t12, 1'b0, i[5:3], 1'b0, i[2:0], 8'h00, 1'b0, i[8:6]};
    end
    if (g <= 5'd7) begin
      case (i[12:11])
        2'b00: t12 = 12'hE3B;
        2'b01: t12 = 12'hE35;
        2'b10: t12 = 12'hE29;
        default: t12 = 12'hE25;
      endcase
      return {1'b0, t12, 1'b0, i[10:8], 1'b0, i[10:8], 4'h0, i[7:0]};
    end
    if (g == 5'd8 && !i[10]) begin
      case (op)
        4'd2:  return {1'b0, 12'hE1B, 4'h0, 1'b0, i[2:0], 1'b0, i[5:3], 1'b0, 2'b00, 1'b1, 1'b0, i[2:0]};
        4'd3:  return {1'b0, 12'hE1B, 4'h0, 1'b0, i[2:0], 1'b0, i[5:3], 1'b0, 2'b01, 1'b1, 1'b0, i[2:0]};
        4'd4:  return {1'b0, 12'hE1B, 4'h0, 1'b0, i[2:0], 1'b0, i[5:3], 1'b0, 2'b10, 1'b1, 1'b0, i[2:0]};
        4'd7:  return {1'b0, 12'hE1B, 4'h0, 1'b0, i[2:0], 1'b0, i[5:3], 1'b0, 2'b11, 1'b1, 1'b0, i[2:0]};
        4'd9:  return {1'b0, 12'hE27, 1'b0, i[5:3], 1'b0, i[2:0], 12'h000};
        4'd13: return {1'b0, 12'hE01, 1'b0, i[2:0], 4'h0, 1'b0, i[2:0], 4'h9, 1'b0, i[5:3]};
        default: begin
          case (op)
            4'd0: t12 = 12'hE01;  4'd1: t12 = 12'hE03;
            4'd5: t12 = 12'hE0B;  4'd6: t12 = 12'hE0D;
            4'd8: t12 = 12'hE11;  4'd10: t12 = 12'hE15;
            4'd11: t12 = 12'hE17; 4'd12: t12 = 12'hE19;
            4'd14: t12 = 12'hE1D; default: t12 = 12'hE1F;
          endcase
          return {1'b0, t12, 1'b0, i[2:0], 1'b0, i[2:0], 8'h00, 1'b0, i[5:3]};
        end
      endcase
    end
    if (g == 5'd8) begin
      if (op >= 4'd1 && op <= 4'd3)  return {1'b0, 12'hE08, rdh, rdh, 8'h00, rsh};
      if (op >= 4'd5 && op <= 4'd7)  return {1'b0, 12'hE15, rdh, rdh, 8'h00, rsh};
      if (op >= 4'd9 && op <= 4'd11) return {1'b0, 12'hE1A, rdh, rdh, 8'h00, rsh};
      if (op == 4'd12 || op == 4'd13) return {1'b0, 28'hE12FFF1, rsh};
      if ((op == 4'd14 || op == 4'd15) && v5) return {1'b0, 28'hE12FFF3, rsh};
    end
    return {1'b1, 32'hDEADC0DE};
  endfunction

  function automatic string req_tag(input logic [15:0] i);
    logic [4:0] g;
    logic [3:0] op;
    g  = i[15:11];
    op = i[9:6];
    if (g <= 5'd2) return "R3";
    if (g == 5'd3) return "R4";
    if (g <= 5'd7) return "R5";
    if (g > 5'd8)  return "R13";
    if (!i[10]) begin
      if (op == 4'd2 || op == 4'd3 || op == 4'd4 || op == 4'd7) return "R7";
      if (op == 4'd9)  return "R8";
      if (op == 4'd13) return "R9";
      return "R6";
    end
    if (op == 4'd12 || op == 4'd13) return "R11";
    if (op == 4'd14 || op == 4'd15) return "R12";
    if (op == 4'd0 || op == 4'd4 || op == 4'd8) return "R13";
    return "R10";
  endfunction

  task automatic check_vec(input logic [15:0] i, input logic v5, input string tag);
    logic [32:0] exp;
    exp = ref_model(i, v5);
    checks++;
    if (o_word !== exp[31:0] || o_undef !== exp[32] || o_valid !== !exp[32]) begin
      failures++;
      $display("FAIL %s instr=%04h v5=%0b: got word=%08h valid=%0b undef=%0b, expected word=%08h valid=%0b undef=%0b",
               tag, i, v5, o_word, o_valid, o_undef, exp[31:0], !exp[32], exp[32]);
    end
  endtask

  // one vector per cycle: drive at negedge, check previous vector at next negedge
  logic [15:0] prev_i;
  logic        prev_v;
  bit          have_prev;

  task automatic push(input logic [15:0] i, input logic v5);
    @(negedge clk);
    if (have_prev) check_vec(prev_i, prev_v, req_tag(prev_i));
    i_instr   = i;
    i_v5_en   = v5;
    prev_i    = i;
    prev_v    = v5;
    have_prev = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    have_prev = 1'b0;
    rst     = 1'b1;
    i_instr = 16'h0000;
    i_v5_en = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (o_word !== 32'h0 || o_valid !== 1'b0 || o_undef !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset: got word=%08h valid=%0b undef=%0b, expected word=00000000 valid=0 undef=0",
               o_word, o_valid, o_undef);
    end
    rst = 1'b0;

    // R2: result follows one edge later and holds between edges
    i_instr = 16'h4168; i_v5_en = 1'b0;
    @(negedge clk);
    check_vec(16'h4168, 1'b0, "R2");
    i_instr = 16'hFFFF;
    #1;
    check_vec(16'h4168, 1'b0, "R2");

    // exhaustive sweep, both enable values (R3..R13)
    for (int v = 0; v < 2; v++)
      for (int k = 0; k < 65536; k++)
        push(16'(k), v[0]);

    // seeded random mix plus directed corners (R12, R13)
    for (int n = 0; n < 1500; n++)
      push(16'($urandom), 1'($urandom));
    push(16'h47F8, 1'b1);  // R12 code 15 with enable
    push(16'h47F8, 1'b0);  // R12 code 15 without enable
    push(16'h4700, 1'b1);  // R11 code 12
    push(16'h4400, 1'b1);  // R13 code 0
    push(16'hFFFF, 1'b1);  // R13 top group
    push(16'h0000, 1'b0);
    @(negedge clk);
    check_vec(prev_i, prev_v, req_tag(prev_i));

    done = 1'b1;
    report();
  end
endmodule